// File: doc/BRIEF.md
# Byte-Packing Host/Engine Data Buffer

This block sits between a 16-bit host data register and a byte-wide serial engine. On the transmit side the host drops two bytes at a time into a small queue, and the engine takes them out one byte per pop in the order they will go on the wire. On the receive side the engine adds one byte per push, and the host takes up to two bytes per read. Each side has its own byte count. A run-time byte-order select sets which half of the host word is the earlier byte in the stream.

The block does not block or stall when it runs empty or full. It reports those conditions instead. Each condition goes out as a one-cycle pulse that the surrounding status logic uses to set or clear its flags: transmit underflow, transmit ready, receive overrun and receive ready. When the controller enable is low, the engine side is ignored. The host side keeps working.

Top module: `pack4_buffer`

## Requirements
- R1: After a synchronous reset, both byte counts are 0, `host_rdata` is 0 and every status pulse output is 0.
- R2: With `big_endian` low, a host write queues `host_wdata[7:0]` as the earlier transmit byte and `host_wdata[15:8]` as the later one, and `tx_count` rises by 2. Pops present bytes on `eng_tx_byte` oldest first, and each pop lowers `tx_count` by 1.
- R3: With `big_endian` high, the byte order is reversed in both directions. On a write, `host_wdata[15:8]` is the earlier transmit byte. On a read, the earlier received byte is returned in `host_rdata[15:8]`.
- R4: An enabled pop while `tx_count` is 0 pulses both `tx_underflow_set` and `tx_ready_set` for one cycle after the pop edge, and `tx_count` stays 0.
- R5: Every host write pulses `tx_underflow_clr` in the following cycle. `tx_ready_clr` pulses only when that write brings `tx_count` to 4.
- R6: A host write made while fewer than 2 transmit slots are free is dropped. `tx_count` and the queued bytes are unchanged.
- R7: Each enabled push stores `eng_rx_byte` and pulses `rx_ready_set`. With `big_endian` low, a read of 2 or more held bytes returns {later, earlier} and lowers `rx_count` by 2. Read data appears one cycle after the read.
- R8: An enabled push while 4 bytes are held pulses `rx_overrun_set` and `rx_ready_set`, drops the byte, and leaves the held bytes and `rx_count` (4) unchanged.
- R9: Every host read pulses `rx_overrun_clr` in the following cycle.
- R10: A read with exactly 1 byte held returns that byte with the other half zero: {0, byte} little-endian, {byte, 0} big-endian. `rx_count` goes to 0. A read with nothing held returns 0.
- R11: After a read, the remaining receive bytes move down, so the next read starts at the oldest unread byte.
- R12: While `enable` is low, engine pushes and pops change no count and produce no set pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; engine accesses are ignored when low |
| big_endian | input | 1 | Byte order select for host words |
| host_wr | input | 1 | Host write strobe for the data register |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host read strobe for the data register |
| host_rdata | output | 16 | Registered host read data |
| eng_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Oldest queued transmit byte |
| eng_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Receive byte from the engine |
| tx_count | output | 3 | Transmit bytes held |
| rx_count | output | 3 | Receive bytes held |
| tx_underflow_set | output | 1 | Pulse: pop while transmit side empty |
| tx_ready_set | output | 1 | Pulse: transmit side wants data |
| tx_underflow_clr | output | 1 | Pulse: host wrote the data register |
| tx_ready_clr | output | 1 | Pulse: transmit side became full |
| rx_overrun_set | output | 1 | Pulse: push while receive side full |
| rx_ready_set | output | 1 | Pulse: receive byte arrived |
| rx_overrun_clr | output | 1 | Pulse: host read the data register |

## Verification
Transmit packing is tested with distinct byte values in each half of the word, under both byte orders, so the bench can tell a swapped pair from a correct one. It also fills the queue to 4 bytes and then writes again, which separates a dropped write from one that overwrote held bytes. Receive packing is tested with 1, 2, 3 and 5 pushes before reads: these show the zero fill for a lone byte, the shift-down of a leftover byte, and the dropped fifth byte. A separate pass with enable low confirms that the engine strobes leave both counts and all pulses untouched.

// File: rtl/pack4_pkg.sv
package pack4_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  // byte of a host word that travels first on the serial side
  function automatic byte_t lead_byte(word_t w, logic be);
    return be ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic byte_t trail_byte(word_t w, logic be);
    return be ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  // build a host word from the earlier and later byte of the stream
  function automatic word_t join_pair(byte_t early, byte_t late, logic be);
    return be ? {early, late} : {late, early};
  endfunction
endpackage

// File: rtl/pack4_tx_lane.sv
module pack4_tx_lane import pack4_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          be,
  input  logic          host_wr,
  input  word_t         host_wdata,
  input  logic          eng_pop,
  output byte_t         eng_byte,
  output logic [CW-1:0] count,
  output logic          set_under,
  output logic          set_ready,
  output logic          clr_under,
  output logic          clr_ready
);
  byte_t         mem [DEPTH];
  byte_t         nxt [DEPTH];
  logic [CW-1:0] cnt, base, nxt_cnt;
  logic          pop_ok, pop_empty, wr_ok;

  always_comb begin
    pop_ok    = eng_pop && en && (cnt != '0);
    pop_empty = eng_pop && en && (cnt == '0);
    base      = cnt - CW'(pop_ok);
    wr_ok     = host_wr && (int'(base) <= DEPTH - 2);
    for (int i = 0; i < DEPTH; i++) nxt[i] = mem[i];
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt[i] = mem[i + 1];
      nxt[DEPTH-1] = '0;
    end
    if (wr_ok) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == base)         nxt[i] = lead_byte(host_wdata, be);
        if (CW'(i) == base + CW'(1)) nxt[i] = trail_byte(host_wdata, be);
      end
    end
    nxt_cnt = base + (wr_ok ? CW'(2) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt       <= '0;
      set_under <= 1'b0;
      set_ready <= 1'b0;
      clr_under <= 1'b0;
      clr_ready <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
      cnt       <= nxt_cnt;
      set_under <= pop_empty;
      set_ready <= pop_empty;
      clr_under <= host_wr;
      clr_ready <= wr_ok && (nxt_cnt == CW'(DEPTH));
    end
  end

  assign eng_byte = mem[0];
  assign count    = cnt;

  // R6: occupancy never exceeds the storage
  p_tx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R4: empty pop flags underflow and ready, count held
  p_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (en && eng_pop && cnt == '0 && !host_wr) |=> (set_under && set_ready && cnt == '0));
  // R5: any host write clears underflow next cycle
  p_wr_clears_r5: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> clr_under);
  // R12: disabled engine leaves count alone
  p_tx_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!en && !host_wr) |=> (cnt == $past(cnt) && !set_under));
endmodule

// File: rtl/pack4_rx_lane.sv
module pack4_rx_lane import pack4_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          be,
  input  logic          host_rd,
  output word_t         host_rdata,
  input  logic          eng_push,
  input  byte_t         eng_byte,
  output logic [CW-1:0] count,
  output logic          set_ovr,
  output logic          set_ready,
  output logic          clr_ovr
);
  byte_t         mem [DEPTH];
  byte_t         nxt [DEPTH];
  logic [CW-1:0] cnt, base, nxt_cnt;
  logic [1:0]    take;
  logic          push_ok, push_full;
  byte_t         b_early, b_late;

  always_comb begin
    take    = host_rd ? ((cnt >= CW'(2)) ? 2'd2 : 2'(cnt)) : 2'd0;
    b_early = (cnt >= CW'(1)) ? mem[0] : '0;
    b_late  = (cnt >= CW'(2)) ? mem[1] : '0;
    base    = cnt - CW'(take);
    for (int i = 0; i < DEPTH; i++) nxt[i] = mem[i];
    if (take == 2'd1) begin
      for (int i = 0; i < DEPTH - 1; i++) nxt[i] = mem[i + 1];
      nxt[DEPTH-1] = '0;
    end else if (take == 2'd2) begin
      for (int i = 0; i < DEPTH - 2; i++) nxt[i] = mem[i + 2];
      nxt[DEPTH-2] = '0;
      nxt[DEPTH-1] = '0;
    end
    push_full = en && eng_push && (base == CW'(DEPTH));
    push_ok   = en && eng_push && !push_full;
    if (push_ok) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == base) nxt[i] = eng_byte;
    end
    nxt_cnt = base + CW'(push_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      cnt        <= '0;
      host_rdata <= '0;
      set_ovr    <= 1'b0;
      set_ready  <= 1'b0;
      clr_ovr    <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
      cnt       <= nxt_cnt;
      if (host_rd) host_rdata <= join_pair(b_early, b_late, be);
      set_ovr   <= push_full;
      set_ready <= en && eng_push;
      clr_ovr   <= host_rd;
    end
  end

  assign count = cnt;

  // R8: push into a full side flags overrun and keeps the count
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (en && eng_push && !host_rd && cnt == CW'(DEPTH)) |=> (set_ovr && set_ready && cnt == CW'(DEPTH)));
  // R7: accepted push grows the count by one
  p_push_step_r7: assert property (@(posedge clk) disable iff (rst)
    (en && eng_push && !host_rd && cnt < CW'(DEPTH)) |=> (cnt == $past(cnt) + CW'(1) && !set_ovr));
  // R9: host read clears overrun next cycle
  p_rd_clears_r9: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> clr_ovr);
  // R12: disabled engine leaves receive side alone
  p_rx_idle_r12: assert property (@(posedge clk) disable iff (rst)
    (!en && !host_rd) |=> ($stable(cnt) && !set_ready && !set_ovr));
endmodule

// File: rtl/pack4_buffer.sv
module pack4_buffer import pack4_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          big_endian,
  input  logic          host_wr,
  input  logic [15:0]   host_wdata,
  input  logic          host_rd,
  output logic [15:0]   host_rdata,
  input  logic          eng_pop,
  output logic [7:0]    eng_tx_byte,
  input  logic          eng_push,
  input  logic [7:0]    eng_rx_byte,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          tx_underflow_set,
  output logic          tx_ready_set,
  output logic          tx_underflow_clr,
  output logic          tx_ready_clr,
  output logic          rx_overrun_set,
  output logic          rx_ready_set,
  output logic          rx_overrun_clr
);
  pack4_tx_lane #(.DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst(rst), .en(enable), .be(big_endian),
    .host_wr(host_wr), .host_wdata(host_wdata),
    .eng_pop(eng_pop), .eng_byte(eng_tx_byte), .count(tx_count),
    .set_under(tx_underflow_set), .set_ready(tx_ready_set),
    .clr_under(tx_underflow_clr), .clr_ready(tx_ready_clr)
  );

  pack4_rx_lane #(.DEPTH(DEPTH), .CW(CW)) u_rx (
    .clk(clk), .rst(rst), .en(enable), .be(big_endian),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_byte(eng_rx_byte), .count(rx_count),
    .set_ovr(rx_overrun_set), .set_ready(rx_ready_set), .clr_ovr(rx_overrun_clr)
  );
endmodule

// File: tb/pack4_buffer_tb.sv
module pack4_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, big_endian = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, eng_pop = 1'b0, eng_push = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
  logic [2:0]  tx_count, rx_count;
  logic        tx_underflow_set, tx_ready_set, tx_underflow_clr, tx_ready_clr;
  logic        rx_overrun_set, rx_ready_set, rx_overrun_clr;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  pack4_buffer dut_i (
    .clk(clk), .rst(rst), .enable(enable), .big_endian(big_endian),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_pop(eng_pop), .eng_tx_byte(eng_tx_byte), .eng_push(eng_push), .eng_rx_byte(eng_rx_byte),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_underflow_set(tx_underflow_set), .tx_ready_set(tx_ready_set),
    .tx_underflow_clr(tx_underflow_clr), .tx_ready_clr(tx_ready_clr),
    .rx_overrun_set(rx_overrun_set), .rx_ready_set(rx_ready_set), .rx_overrun_clr(rx_overrun_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] w);
    host_wr = 1'b1; host_wdata = w;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(output logic [15:0] w);
    host_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0; w = host_rdata;
  endtask

  task automatic pop(output logic [7:0] b);
    b = eng_tx_byte; eng_pop = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    eng_rx_byte = b; eng_push = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_push = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 tx_count", tx_count, 0);
    check("R1 rx_count", rx_count, 0);
    check("R1 rdata", host_rdata, 0);
    check("R1 pulses", {tx_underflow_set, tx_ready_set, tx_underflow_clr, tx_ready_clr,
                        rx_overrun_set, rx_ready_set, rx_overrun_clr}, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b;
    big_endian = 1'b0;
    wr(16'hA1B2);
    check("R2 count after write", tx_count, 2);
    check("R5 underflow clr", tx_underflow_clr, 1);
    check("R5 no ready clr at 2", tx_ready_clr, 0);
    pop(b); check("R2 first byte", b, 8'hB2);
    pop(b); check("R2 second byte", b, 8'hA1);
    check("R2 count drained", tx_count, 0);
    big_endian = 1'b1;
    wr(16'hC3D4);
    pop(b); check("R3 be first byte", b, 8'hC3);
    pop(b); check("R3 be second byte", b, 8'hD4);
    big_endian = 1'b0;
  endtask

  task automatic t_underflow();
    logic [7:0] b;
    pop(b);
    check("R4 underflow set", tx_underflow_set, 1);
    check("R4 ready set", tx_ready_set, 1);
    check("R4 count", tx_count, 0);
  endtask

  task automatic t_tx_full();
    logic [7:0] b;
    wr(16'h1122);
    wr(16'h3344);
    check("R5 ready clr at full", tx_ready_clr, 1);
    check("R5 count full", tx_count, 4);
    wr(16'h5566);
    check("R6 count unchanged", tx_count, 4);
    check("R5 underflow clr any write", tx_underflow_clr, 1);
    check("R5 no ready clr when dropped", tx_ready_clr, 0);
    pop(b); check("R6 byte0", b, 8'h22);
    pop(b); check("R6 byte1", b, 8'h11);
    pop(b); check("R6 byte2", b, 8'h44);
    pop(b); check("R6 byte3", b, 8'h33);
  endtask

  task automatic t_rx_basic();
    logic [15:0] w;
    push(8'h5A);
    check("R7 ready set", rx_ready_set, 1);
    push(8'h6B);
    check("R7 count", rx_count, 2);
    rd(w);
    check("R7 le word", w, 16'h6B5A);
    check("R7 count after read", rx_count, 0);
    check("R9 overrun clr", rx_overrun_clr, 1);
    big_endian = 1'b1;
    push(8'h01); push(8'h02);
    rd(w);
    check("R3 be word", w, 16'h0102);
    big_endian = 1'b0;
  endtask

  task automatic t_overrun();
    logic [15:0] w;
    push(8'h10); push(8'h20); push(8'h30); push(8'h40);
    check("R8 count full", rx_count, 4);
    push(8'h50);
    check("R8 overrun set", rx_overrun_set, 1);
    check("R8 ready set", rx_ready_set, 1);
    check("R8 count held", rx_count, 4);
    rd(w); check("R8 first pair", w, 16'h2010);
    rd(w); check("R11 second pair", w, 16'h4030);
    check("R11 drained", rx_count, 0);
  endtask

  task automatic t_partial();
    logic [15:0] w;
    push(8'h77);
    rd(w);
    check("R10 lone le", w, 16'h0077);
    check("R10 count", rx_count, 0);
    big_endian = 1'b1;
    push(8'h88);
    rd(w);
    check("R10 lone be", w, 16'h8800);
    big_endian = 1'b0;
    rd(w);
    check("R10 empty read", w, 16'h0000);
  endtask

  task automatic t_shift();
    logic [15:0] w;
    push(8'h01); push(8'h02); push(8'h03);
    rd(w);
    check("R11 first", w, 16'h0201);
    check("R11 count left", rx_count, 1);
    push(8'h04);
    rd(w);
    check("R11 shifted", w, 16'h0403);
  endtask

  task automatic t_disabled();
    logic [7:0] b;
    enable = 1'b0;
    pop(b);
    check("R12 no underflow", tx_underflow_set, 0);
    push(8'hAA);
    check("R12 rx count", rx_count, 0);
    check("R12 no rx ready", rx_ready_set, 0);
    wr(16'h1234);
    pop(b);
    check("R12 tx count held", tx_count, 2);
    enable = 1'b1;
    pop(b); check("R12 byte kept", b, 8'h34);
    pop(b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    enable = 1'b1;
    t_tx_order();
    t_underflow();
    t_tx_full();
    t_rx_basic();
    t_overrun();
    t_partial();
    t_shift();
    t_disabled();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule